// File: doc/BRIEF.md
# Sleep Wake-Up Start-Up Sequencer

This block brings a small processor core back out of sleep. A sleep request, qualified by a sleep-mode code, gates the CPU clock off. A later wake event starts a sequence. If the mode kept the clock source running, the clock comes back at once. Otherwise the sequencer waits for the oscillator's ready indication and then counts a start-up delay. That delay is fixed for RC and external clocks and selectable for a crystal. Once the clock counts as stable, the CPU clock-enable goes high. A fixed ISR-entry latency then follows before a one-cycle strobe tells the core to fetch its interrupt vector.

A busy output covers the whole interval from the wake event to that strobe. It lets a power monitor attribute the energy spent while the core cannot yet do useful work. Stray wake events and sleep requests that arrive during a sequence are dropped, so a sequence always runs to completion with the timing it started with.

Top module: `wake_seq`

## Requirements
- R1: While reset is asserted and right after it is released, cpuClkEn is 1, busy is 0 and isrStart is 0 (the core is running).
- R2: A sleepReq sampled while running sets cpuClkEn to 0 in the next cycle with busy staying 0, and the block stays asleep until a wake event, whatever oscReady does. The sleep-mode code is captured at that edge.
- R3: Shallow modes are code 0 (idle), 3 (standby) and 4 (extended standby). A wake from one of them raises cpuClkEn and busy together in the cycle after the wake edge, with no oscillator wait and no start-up count.
- R4: Deep modes are codes 1, 2, 5, 6 and 7. On a wake from one of them, cpuClkEn stays 0 until oscReady is sampled high. The start-up count begins only after that sample.
- R5: With clkSrc 00 (internal RC), 01 (external clock) or 11 (treated as RC), the start-up count is 6 cycles. If oscReady is first seen high k cycles after busy rises, cpuClkEn is 0 for k+1+6 busy cycles.
- R6: With clkSrc 10 (crystal), xtalSel selects the start-up count: 00 = 0, 01 = 256, 10 = 1000, 11 = 16000 cycles. The count is added to the oscillator wait in the same way as in R5.
- R7: isrStart is a one-cycle pulse that follows exactly 13 cycles in which cpuClkEn is 1 and busy is 1. It is preceded by the cpuClkEn rise, and the core is running in the cycle after it.
- R8: busy rises in the cycle after the wake edge. It stays high through the isrStart cycle and is 0 in the cycle after. A wakeEvt while running leaves busy at 0 and cpuClkEn at 1.
- R9: A wakeEvt during a running sequence is ignored: it changes neither the start-up timing nor the latency.
- R10: A sleepReq during a running sequence is ignored: after isrStart the core keeps running, with cpuClkEn held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Request to enter sleep; honoured only while running |
| sleepMode | input | 3 | Sleep-mode code captured with sleepReq |
| clkSrc | input | 2 | System clock source type |
| xtalSel | input | 2 | Crystal start-up count selector |
| oscReady | input | 1 | Oscillator ready indication |
| wakeEvt | input | 1 | Wake event; honoured only while asleep |
| cpuClkEn | output | 1 | CPU clock enable |
| busy | output | 1 | High from the wake event through the ISR strobe |
| isrStart | output | 1 | One-cycle interrupt-vector-fetch strobe |

## Verification
The hardest cases to reach from the ports are stray wake events and sleep requests that land inside a running sequence. These must be shown to have no effect on timing that is already long and depends on the oscillator. The bench injects them at fixed cycle offsets inside each sequence. The offsets are chosen so that they fall into the oscillator wait, the start-up count or the ISR latency, depending on the mode, source and oscReady lag. The bench then compares the measured dark-clock and latency counts with values computed from the mode and source tables. The 16000-cycle quartz case and the zero-count crystal case are directed. The remaining combinations come from a seeded random sweep.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_OSC   = 3'd2,
    ST_START = 3'd3,
    ST_LAT   = 3'd4,
    ST_ISR   = 3'd5
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadStart;
    logic loadLat;
    logic dec;
  } seqStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic cntZero;
    logic startZero;
  } seqStat_t;

  // idle, standby and extended standby keep the clock source alive
  function automatic logic isShallow(input logic [2:0] mode);
    return (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd4);
  endfunction

endpackage

// File: rtl/wake_seq_dp.sv
module wake_seq_dp
  import wake_seq_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int RC_CYC    = 6,
  parameter int ISR_CYC   = 13,
  parameter int XTAL_CYC0 = 0,
  parameter int XTAL_CYC1 = 256,
  parameter int XTAL_CYC2 = 1000,
  parameter int XTAL_CYC3 = 16000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkSrc,
  input  logic [1:0] xtalSel,
  input  seqStrb_t   strb,
  output seqStat_t   stat
);

  localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(ISR_CYC - 1);
  localparam int               N_XTAL   = 4;

  logic [CNT_W-1:0] xtalTab [N_XTAL];
  logic [CNT_W-1:0] startDelay;
  logic [CNT_W-1:0] cnt;

  generate
    for (genvar g = 0; g < N_XTAL; g++) begin : gXtal
      localparam int CYC = (g == 0) ? XTAL_CYC0 :
                           (g == 1) ? XTAL_CYC1 :
                           (g == 2) ? XTAL_CYC2 : XTAL_CYC3;
      assign xtalTab[g] = CNT_W'(CYC);
    end
  endgenerate

  always_comb begin
    if (clkSrc == 2'b10) startDelay = xtalTab[xtalSel];
    else                 startDelay = CNT_W'(RC_CYC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.loadStart) cnt <= startDelay - CNT_W'(1);
    else if (strb.loadLat)   cnt <= LAT_LOAD;
    else if (strb.dec)       cnt <= cnt - CNT_W'(1);
  end

  assign stat.cntZero   = (cnt == '0);
  assign stat.startZero = (startDelay == '0);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> (cnt != '0));

  // R7
  lat_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLat |=> (cnt == LAT_LOAD));

endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic [2:0] sleepMode,
  input  logic       wakeEvt,
  input  logic       oscReady,
  input  seqStat_t   stat,
  output seqStrb_t   strb,
  output logic       cpuClkEn,
  output logic       busy,
  output logic       isrStart
);

  seqState_e state, stateNxt;
  logic      deepQ;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_RUN:   if (sleepReq) stateNxt = ST_SLEEP;
      ST_SLEEP: if (wakeEvt) begin
                  if (deepQ) stateNxt = ST_OSC;
                  else begin
                    stateNxt     = ST_LAT;
                    strb.loadLat = 1'b1;
                  end
                end
      ST_OSC:   if (oscReady) begin
                  if (stat.startZero) begin
                    stateNxt     = ST_LAT;
                    strb.loadLat = 1'b1;
                  end else begin
                    stateNxt       = ST_START;
                    strb.loadStart = 1'b1;
                  end
                end
      ST_START: if (stat.cntZero) begin
                  stateNxt     = ST_LAT;
                  strb.loadLat = 1'b1;
                end else strb.dec = 1'b1;
      ST_LAT:   if (stat.cntZero) stateNxt = ST_ISR;
                else strb.dec = 1'b1;
      ST_ISR:   stateNxt = ST_RUN;
      default:  stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      deepQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_RUN && sleepReq) deepQ <= !isShallow(sleepMode);
    end
  end

  assign cpuClkEn = (state == ST_RUN) || (state == ST_LAT) || (state == ST_ISR);
  assign busy     = (state == ST_OSC) || (state == ST_START) ||
                    (state == ST_LAT) || (state == ST_ISR);
  assign isrStart = (state == ST_ISR);

  // R7
  isr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    isrStart |=> !isrStart);

  // R7
  isr_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    isrStart |-> (cpuClkEn && busy && $past(cpuClkEn)));

  // R3
  clk_rise_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(isrStart) && cpuClkEn));

  // R4
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OSC && !oscReady) |=> !cpuClkEn);

endmodule

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int CNT_W     = 14,
  parameter int RC_CYC    = 6,
  parameter int ISR_CYC   = 13,
  parameter int XTAL_CYC0 = 0,
  parameter int XTAL_CYC1 = 256,
  parameter int XTAL_CYC2 = 1000,
  parameter int XTAL_CYC3 = 16000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic [2:0] sleepMode,
  input  logic [1:0] clkSrc,
  input  logic [1:0] xtalSel,
  input  logic       oscReady,
  input  logic       wakeEvt,
  output logic       cpuClkEn,
  output logic       busy,
  output logic       isrStart
);

  import wake_seq_pkg::*;

  seqStrb_t strb;
  seqStat_t stat;

  wake_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .sleepMode(sleepMode),
    .wakeEvt  (wakeEvt),
    .oscReady (oscReady),
    .stat     (stat),
    .strb     (strb),
    .cpuClkEn (cpuClkEn),
    .busy     (busy),
    .isrStart (isrStart)
  );

  wake_seq_dp #(
    .CNT_W    (CNT_W),
    .RC_CYC   (RC_CYC),
    .ISR_CYC  (ISR_CYC),
    .XTAL_CYC0(XTAL_CYC0),
    .XTAL_CYC1(XTAL_CYC1),
    .XTAL_CYC2(XTAL_CYC2),
    .XTAL_CYC3(XTAL_CYC3)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .clkSrc (clkSrc),
    .xtalSel(xtalSel),
    .strb   (strb),
    .stat   (stat)
  );

endmodule

// File: tb/tb_wake_seq.sv
module tb_wake_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepReq = 1'b0;
  logic [2:0] sleepMode = '0;
  logic [1:0] clkSrc = '0;
  logic [1:0] xtalSel = '0;
  logic       oscReady = 1'b0;
  logic       wakeEvt = 1'b0;
  logic       cpuClkEn, busy, isrStart;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  wake_seq dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
    .clkSrc(clkSrc), .xtalSel(xtalSel), .oscReady(oscReady),
    .wakeEvt(wakeEvt), .cpuClkEn(cpuClkEn), .busy(busy), .isrStart(isrStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit shallowMode(input int mode);
    return (mode == 0) || (mode == 3) || (mode == 4);
  endfunction

  function automatic int startCount(input int src, input int sel);
    if (src != 2) return 6;
    case (sel)
      0: return 0;
      1: return 256;
      2: return 1000;
      default: return 16000;
    endcase
  endfunction

  function automatic int expDark(input int mode, input int src, input int sel, input int lag);
    if (shallowMode(mode)) return 0;
    return lag + 1 + startCount(src, sel);
  endfunction

  task automatic runSeq(input int mode, input int src, input int sel, input int lag,
                        input bit injWake, input bit injSlp);
    int dark = 0;
    int lat = 0;
    bit seen = 1'b0;
    @(negedge clk);
    sleepMode = 3'(mode);
    clkSrc    = 2'(src);
    xtalSel   = 2'(sel);
    oscReady  = 1'b0;
    sleepReq  = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    // R2
    check(cpuClkEn == 1'b0 && busy == 1'b0, "R2 sleep entry", {cpuClkEn, busy}, 0);
    oscReady = 1'b1;
    repeat (3) @(negedge clk);
    // R2
    check(cpuClkEn == 1'b0 && busy == 1'b0, "R2 stays asleep", {cpuClkEn, busy}, 0);
    oscReady = 1'b0;
    wakeEvt  = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      if (i == 0) begin
        // R8
        check(busy == 1'b1, "R8 busy rise", busy, 1);
        if (shallowMode(mode))
          check(cpuClkEn == 1'b1, "R3 shallow clock back at once", cpuClkEn, 1);
        else
          check(cpuClkEn == 1'b0, "R4 deep clock held off", cpuClkEn, 0);
      end
      if (busy && !cpuClkEn) dark++;
      else if (busy && cpuClkEn && !isrStart) lat++;
      if (isrStart) seen = 1'b1;
      oscReady = (i >= lag);
      wakeEvt  = injWake && (i == 2 || i == lag + 3);
      sleepReq = injSlp && busy && cpuClkEn && !isrStart && (lat == 5);
      @(negedge clk);
    end
    wakeEvt  = 1'b0;
    sleepReq = 1'b0;
    check(seen, "R7 strobe seen", seen, 1);
    // R4 R5 R6 R9
    check(dark == expDark(mode, src, sel, lag),
          injWake ? "R9 dark count with stray wake" :
          (src == 2 ? "R6 crystal start-up" : "R5 RC start-up"),
          dark, expDark(mode, src, sel, lag));
    // R7
    check(lat == 13, "R7 ISR latency", lat, 13);
    // R7 R8
    check(isrStart == 1'b0 && busy == 1'b0 && cpuClkEn == 1'b1,
          "R8 after strobe", {isrStart, busy, cpuClkEn}, 1);
    if (injSlp) begin
      repeat (3) @(negedge clk);
      // R10
      check(cpuClkEn == 1'b1 && busy == 1'b0, "R10 sleep request ignored",
            {cpuClkEn, busy}, 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1
    check(cpuClkEn == 1'b1 && busy == 1'b0 && isrStart == 1'b0, "R1 in reset",
          {cpuClkEn, busy, isrStart}, 4);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuClkEn == 1'b1 && busy == 1'b0 && isrStart == 1'b0, "R1 after reset",
          {cpuClkEn, busy, isrStart}, 4);

    // R8: wake while running is ignored
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && cpuClkEn == 1'b1, "R8 wake while running", {busy, cpuClkEn}, 1);

    runSeq(1, 0, 0, 0, 1'b0, 1'b0);  // R5 RC, power-down
    runSeq(2, 1, 0, 4, 1'b0, 1'b0);  // R5 external clock, oscillator lag
    runSeq(6, 3, 0, 2, 1'b0, 1'b0);  // R5 code 11 treated as RC
    runSeq(0, 2, 3, 0, 1'b0, 1'b0);  // R3 idle
    runSeq(3, 2, 2, 5, 1'b0, 1'b0);  // R3 standby
    runSeq(4, 0, 0, 1, 1'b0, 1'b0);  // R3 extended standby
    runSeq(5, 2, 0, 2, 1'b0, 1'b0);  // R6 crystal 0
    runSeq(2, 2, 1, 0, 1'b0, 1'b0);  // R6 crystal 256
    runSeq(1, 2, 2, 3, 1'b0, 1'b0);  // R6 ceramic 1000
    runSeq(1, 2, 3, 1, 1'b0, 1'b0);  // R6 quartz 16000
    runSeq(2, 0, 0, 3, 1'b1, 1'b1);  // R9 R10 stray events
    runSeq(0, 0, 0, 0, 1'b1, 1'b1);  // R9 R10 stray events, shallow

    for (int t = 0; t < 30; t++) begin
      int mode = int'($urandom_range(7, 0));
      int src  = int'($urandom_range(3, 0));
      int sel  = int'($urandom_range(2, 0));
      int lag  = int'($urandom_range(6, 0));
      bit iw   = 1'($urandom_range(1, 0));
      bit is   = 1'($urandom_range(1, 0));
      runSeq(mode, src, sel, lag, iw, is);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule